// File: doc/BRIEF.md
# Banked Gamma Correction Stage with Delta-Coded Table

This block applies a per-channel gamma curve to an RGB pixel stream. Each 10-bit input component is an index into a 1024-entry table per channel. The tables are loaded through a small register port. The index space is split into four banks of 256 entries. A bank register picks which bank the table window writes into, and it also picks the data layout. In the wide layout, red and green share one word and blue goes through a second window. In the narrow layout, a single word carries all three components.

Each table can be stored in one of two ways. In absolute form, every entry is read as it is. In delta form, even entries hold absolute values and each odd entry holds the step from its even neighbour. The lookup rebuilds the absolute value by adding the step, or by subtracting it when the curve is flagged as descending. The result is clamped to the 12-bit range.

Pixels enter and leave through valid/ready handshakes, and a two-stage pipeline sits between them. Back-pressure follows these rules:
- The input is accepted only when the output register is empty or is being consumed.
- A stalled output keeps its data and its valid flag.
- No pixel is dropped or reordered.

Relay mode and a disabled table both pass each component through unchanged, widened to 12 bits. A global enable freezes the pipeline and holds both handshakes idle. A line-width counter flags, with a sticky error, any end-of-line marker that arrives at the wrong position.

Top module: `gamma_lut_stage`

## Requirements
- R1: After reset the global enable (bit 0 at offset 0x000) is 0, and `out_valid`, `in_ready` and `err_o` are low. While enable is 0, `out_valid` and `in_ready` stay low and pixels held in the pipeline are kept.
- R2: The registers read back on `reg_rdata` in the same cycle the address is presented:
  - enable at 0x000, bit 0;
  - configuration at 0x004, bits 3:0;
  - size at 0x008, with width in bits 28:16 and line count in bits 12:0;
  - bank at 0x00C, with bank in bits 1:0 and wide mode in bit 2.
- R3: When configuration bit 0 (relay) is 1, or bit 1 (table enable) is 0, each output component equals its input shifted left by two. `out_eol` follows `in_eol`.
- R4: In wide mode (bank bit 2 = 1), a write to the primary window stores red from data bits 11:0 and green from bits 23:12. A write to the secondary window stores blue from bits 11:0. The entry stored is bank × 256 + entry. The primary window is 0x400 + 4 × entry and the secondary window is 0x800 + 4 × entry. Input bits 9:8 of a component select the bank and bits 7:0 select the entry.
- R5: In narrow mode (bank bit 2 = 0), a primary-window write stores red from bits 29:20, green from bits 19:10 and blue from bits 9:0, each multiplied by 4. Secondary-window writes are ignored in this mode.
- R6: With configuration bit 3 (delta) set and bit 2 clear, an odd index yields the preceding even entry plus the stored value, clamped to 4095.
- R7: With bits 3 and 2 both set, an odd index yields the preceding even entry minus the stored value, clamped to 0.
- R8: Pixels pass through two register stages. A pixel accepted at edge k is presented from edge k+1 when the pipeline advances. Under any `out_ready` pattern, outputs are held while stalled, and no pixel is lost or reordered.
- R9: `err_o` is set when an accepted pixel's `in_eol` disagrees with its being at column width−1. It stays set until the size register is written, and that write also resets the column to 0.
- R10: With delta off and the table enabled, odd and even entries are both returned exactly as stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Register read data (combinational) |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with valid |
| in_r | input | 10 | Red component / table index |
| in_g | input | 10 | Green component / table index |
| in_b | input | 10 | Blue component / table index |
| in_eol | input | 1 | Last pixel of a line |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts output |
| out_r | output | 12 | Corrected red |
| out_g | output | 12 | Corrected green |
| out_b | output | 12 | Corrected blue |
| out_eol | output | 1 | End-of-line marker aligned with output |
| err_o | output | 1 | Sticky line-geometry error |

## Verification
Two events can land in the same cycle: a downstream stall and the global enable being cleared. In that case the pipeline must freeze and must not lose data. The bench provokes this by holding `out_ready` low until both stages hold a pixel, and then writing enable to 0. It checks that both handshakes stay low, including after `out_ready` returns high, and then re-enables the block. The scoreboard then requires both held pixels to emerge in order with the values predicted from the table model. Randomised `out_ready` over a long stream of banked delta lookups also exercises a stall coinciding with a new acceptance on every cycle.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  localparam int unsigned REG_AW = 12;
  localparam int unsigned OUT_W  = 12;
  localparam logic [REG_AW-1:0] A_ENABLE = 12'h000;
  localparam logic [REG_AW-1:0] A_CONFIG = 12'h004;
  localparam logic [REG_AW-1:0] A_SIZE   = 12'h008;
  localparam logic [REG_AW-1:0] A_BANK   = 12'h00C;
  localparam logic [1:0] WIN_PRI = 2'b01;
  localparam logic [1:0] WIN_SEC = 2'b10;

  // configuration bits: [3] delta, [2] descending, [1] table on, [0] relay
  typedef struct packed {
    logic delta;
    logic desc;
    logic tbl_on;
    logic relay;
  } cfg_t;
endpackage

// File: rtl/gamma_regs.sv
module gamma_regs
  import gamma_lut_pkg::*;
#(
  parameter int BANKS   = 4,
  parameter int ENTRIES = 256,
  localparam int BKW    = $clog2(BANKS),
  localparam int EW     = $clog2(ENTRIES),
  localparam int IDXW   = BKW + EW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_we,
  output logic [31:0]       reg_rdata,
  output logic              en_o,
  output cfg_t              cfg_o,
  output logic [12:0]       width_o,
  output logic              size_wr_o,
  output logic [2:0]        lut_we_o,
  output logic [IDXW-1:0]   lut_idx_o,
  output logic [2:0][OUT_W-1:0] lut_val_o
);
  logic            en_q;
  cfg_t            cfg_q;
  logic [12:0]     wid_q, hgt_q;
  logic [BKW-1:0]  bank_q;
  logic            wide_q;
  logic            hit_pri, hit_sec;
  logic [1:0]      unused_wbits;

  assign unused_wbits = reg_wdata[31:30];
  assign hit_pri   = reg_we && (reg_addr[11:10] == WIN_PRI);
  assign hit_sec   = reg_we && (reg_addr[11:10] == WIN_SEC);
  assign size_wr_o = reg_we && (reg_addr == A_SIZE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      cfg_q  <= '0;
      wid_q  <= '0;
      hgt_q  <= '0;
      bank_q <= '0;
      wide_q <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        A_ENABLE: en_q  <= reg_wdata[0];
        A_CONFIG: cfg_q <= cfg_t'(reg_wdata[3:0]);
        A_SIZE: begin
          wid_q <= reg_wdata[28:16];
          hgt_q <= reg_wdata[12:0];
        end
        A_BANK: begin
          bank_q <= reg_wdata[BKW-1:0];
          wide_q <= reg_wdata[2];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_ENABLE: reg_rdata[0]     = en_q;
      A_CONFIG: reg_rdata[3:0]   = cfg_q;
      A_SIZE:   reg_rdata        = {3'b0, wid_q, 3'b0, hgt_q};
      A_BANK:   reg_rdata[2:0]   = {wide_q, bank_q};
      default:  reg_rdata        = '0;
    endcase
  end

  assign lut_idx_o = {bank_q, reg_addr[EW+1:2]};

  always_comb begin
    if (wide_q) begin
      lut_we_o     = {hit_sec, hit_pri, hit_pri};
      lut_val_o[0] = reg_wdata[11:0];
      lut_val_o[1] = reg_wdata[23:12];
      lut_val_o[2] = reg_wdata[11:0];
    end else begin
      lut_we_o     = {3{hit_pri}};
      lut_val_o[0] = {reg_wdata[29:20], 2'b00};
      lut_val_o[1] = {reg_wdata[19:10], 2'b00};
      lut_val_o[2] = {reg_wdata[9:0],   2'b00};
    end
  end

  assign en_o    = en_q;
  assign cfg_o   = cfg_q;
  assign width_o = wid_q;

  a_r4_bank_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_BANK) |=>
      (bank_q == $past(reg_wdata[BKW-1:0]) && wide_q == $past(reg_wdata[2])));
endmodule

// File: rtl/gamma_chan.sv
module gamma_chan
  import gamma_lut_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [OUT_W-1:0] wr_val,
  input  logic [IDXW-1:0]  rd_idx,
  input  logic             delta,
  input  logic             desc,
  output logic [OUT_W-1:0] res
);
  logic [OUT_W-1:0] mem [DEPTH];
  logic [OUT_W-1:0] cur, base;
  logic [OUT_W:0]   sum;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_val;
  end

  assign cur  = mem[rd_idx];
  assign base = mem[{rd_idx[IDXW-1:1], 1'b0}];
  assign sum  = {1'b0, base} + {1'b0, cur};

  always_comb begin
    if (delta && rd_idx[0]) begin
      if (desc) res = (base < cur) ? '0 : base - cur;
      else      res = sum[OUT_W] ? '1 : sum[OUT_W-1:0];
    end else begin
      res = cur;
    end
  end

  a_r6_rising_not_below_base: assert property (@(posedge clk) disable iff (!rst_n)
    (delta && !desc && rd_idx[0]) |-> (res >= base));
  a_r7_falling_not_above_base: assert property (@(posedge clk) disable iff (!rst_n)
    (delta && desc && rd_idx[0]) |-> (res <= base));
endmodule

// File: rtl/gamma_geom.sv
module gamma_geom #(
  parameter int XW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          eol,
  input  logic [XW-1:0] width,
  input  logic          clr,
  output logic          err_o
);
  logic [XW-1:0] x_q;
  logic [XW-1:0] last_col;
  logic          err_q;

  assign last_col = width - XW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q   <= '0;
      err_q <= 1'b0;
    end else if (clr) begin
      x_q   <= '0;
      err_q <= 1'b0;
    end else if (fire) begin
      x_q <= eol ? '0 : x_q + XW'(1);
      if (eol != (x_q == last_col)) err_q <= 1'b1;
    end
  end

  assign err_o = err_q;

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr) |=> err_q);
endmodule

// File: rtl/gamma_lut_stage.sv
module gamma_lut_stage
  import gamma_lut_pkg::*;
#(
  parameter int BANKS   = 4,
  parameter int ENTRIES = 256,
  localparam int DEPTH  = BANKS * ENTRIES,
  localparam int IDXW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_we,
  output logic [31:0]       reg_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDXW-1:0]   in_r,
  input  logic [IDXW-1:0]   in_g,
  input  logic [IDXW-1:0]   in_b,
  input  logic              in_eol,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_r,
  output logic [OUT_W-1:0]  out_g,
  output logic [OUT_W-1:0]  out_b,
  output logic              out_eol,
  output logic              err_o
);
  logic                   en_w, size_wr;
  cfg_t                   cfg_w;
  logic [12:0]            width_w;
  logic [2:0]             lut_we;
  logic [IDXW-1:0]        lut_idx;
  logic [2:0][OUT_W-1:0]  lut_val;
  logic [2:0][OUT_W-1:0]  res;

  logic                   v1_q, v2_q, eol1_q, eol2_q;
  logic [2:0][IDXW-1:0]   px1_q;
  logic [2:0][OUT_W-1:0]  px2_q;
  logic                   adv, bypass;

  gamma_regs #(.BANKS(BANKS), .ENTRIES(ENTRIES)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .en_o(en_w), .cfg_o(cfg_w),
    .width_o(width_w), .size_wr_o(size_wr), .lut_we_o(lut_we),
    .lut_idx_o(lut_idx), .lut_val_o(lut_val)
  );

  for (genvar ch = 0; ch < 3; ch++) begin : g_chan
    gamma_chan #(.DEPTH(DEPTH)) u_chan (
      .clk(clk), .rst_n(rst_n), .wr_en(lut_we[ch]), .wr_idx(lut_idx),
      .wr_val(lut_val[ch]), .rd_idx(px1_q[ch]), .delta(cfg_w.delta),
      .desc(cfg_w.desc), .res(res[ch])
    );
  end

  gamma_geom #(.XW(13)) u_geom (
    .clk(clk), .rst_n(rst_n), .fire(in_valid && in_ready), .eol(in_eol),
    .width(width_w), .clr(size_wr), .err_o(err_o)
  );

  assign adv      = en_w && (!v2_q || out_ready);
  assign in_ready = adv;
  assign bypass   = cfg_w.relay || !cfg_w.tbl_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1_q   <= 1'b0;
      v2_q   <= 1'b0;
      eol1_q <= 1'b0;
      eol2_q <= 1'b0;
      px1_q  <= '0;
      px2_q  <= '0;
    end else if (adv) begin
      v1_q   <= in_valid;
      eol1_q <= in_eol;
      px1_q  <= {in_b, in_g, in_r};
      v2_q   <= v1_q;
      eol2_q <= eol1_q;
      for (int ch = 0; ch < 3; ch++)
        px2_q[ch] <= bypass ? {px1_q[ch], {(OUT_W-IDXW){1'b0}}} : res[ch];
    end
  end

  assign out_valid = v2_q && en_w;
  assign out_r     = px2_q[0];
  assign out_g     = px2_q[1];
  assign out_b     = px2_q[2];
  assign out_eol   = eol2_q;

  a_r1_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_w |=> ($stable(v1_q) && $stable(v2_q)));
  a_r8_data_held_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      ($stable(out_r) && $stable(out_g) && $stable(out_b) && $stable(out_eol)));
  a_r8_valid_held_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid || !en_w));
endmodule

// File: tb/gamma_lut_stage_tb_top.sv
module gamma_lut_stage_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0, in_ready, in_eol = 1'b0;
  logic [9:0]  in_r = '0, in_g = '0, in_b = '0;
  logic        out_valid, out_ready = 1'b1, out_eol, err_o;
  logic [11:0] out_r, out_g, out_b;

  typedef struct packed {
    logic [11:0] r, g, b;
    logic        eol;
  } exp_t;

  int    n_chk = 0, n_bad = 0;
  int    tr[1024], tg[1024], tb[1024];
  int    cfg_m = 0;
  int    bp_mode = 0;
  string cur_req = "R3";
  exp_t  q[$];

  always #2 clk = ~clk;

  gamma_lut_stage dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .in_eol(in_eol), .out_valid(out_valid), .out_ready(out_ready),
    .out_r(out_r), .out_g(out_g), .out_b(out_b), .out_eol(out_eol),
    .err_o(err_o)
  );

  task automatic chk(string req, bit ok, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  function automatic int tab(int ch, int i);
    case (ch)
      0: return tr[i];
      1: return tg[i];
      default: return tb[i];
    endcase
  endfunction

  function automatic int look(int ch, int i);
    int cur  = tab(ch, i);
    int base = tab(ch, i & ~1);
    if (cfg_m[0] || !cfg_m[1]) return i * 4;
    if (cfg_m[3] && (i % 2 == 1)) begin
      if (cfg_m[2]) return (base > cur) ? base - cur : 0;
      return (base + cur > 4095) ? 4095 : base + cur;
    end
    return cur;
  endfunction

  task automatic reg_wr(int a, int d);
    @(negedge clk);
    reg_addr = 12'(a); reg_wdata = 32'(d); reg_we = 1'b1;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic reg_rd_chk(string req, int a, int exp);
    @(negedge clk);
    reg_addr = 12'(a);
    #1 chk(req, reg_rdata == 32'(exp), int'(reg_rdata), exp);
  endtask

  task automatic set_cfg(int v);
    reg_wr(12'h004, v);
    cfg_m = v;
  endtask

  task automatic set12(int idx, int r, int g, int b);
    reg_wr(12'h00C, 4 | (idx >> 8));
    reg_wr(12'h400 + 4 * (idx & 255), (g << 12) | r);
    reg_wr(12'h800 + 4 * (idx & 255), b);
    tr[idx] = r; tg[idx] = g; tb[idx] = b;
  endtask

  task automatic set10(int idx, int r, int g, int b);
    reg_wr(12'h00C, idx >> 8);
    reg_wr(12'h400 + 4 * (idx & 255), (r << 20) | (g << 10) | b);
    tr[idx] = r * 4; tg[idx] = g * 4; tb[idx] = b * 4;
  endtask

  task automatic send(int r, int g, int b, bit eol);
    exp_t e;
    @(negedge clk);
    in_r = 10'(r); in_g = 10'(g); in_b = 10'(b); in_eol = eol; in_valid = 1'b1;
    forever begin
      if (in_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    e.r = 12'(look(0, r)); e.g = 12'(look(1, g)); e.b = 12'(look(2, b)); e.eol = eol;
    q.push_back(e);
    #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic int pool(int k);
    return (k % 4) * 256 + (k / 4) % 8;
  endfunction

  // out_ready pattern changes just after each rising edge
  always @(posedge clk) begin
    #1;
    case (bp_mode)
      0: out_ready = 1'b1;
      1: out_ready = 1'($urandom % 2);
      default: out_ready = 1'b0;
    endcase
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (q.size() == 0) begin
        chk("R8 unexpected output", 1'b0, 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({cur_req, " red"},   out_r == e.r,     int'(out_r),   int'(e.r));
        chk({cur_req, " green"}, out_g == e.g,     int'(out_g),   int'(e.g));
        chk({cur_req, " blue"},  out_b == e.b,     int'(out_b),   int'(e.b));
        chk({cur_req, " eol"},   out_eol == e.eol, int'(out_eol), int'(e.eol));
      end
    end
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 out_valid after reset", out_valid == 1'b0, int'(out_valid), 0);
    chk("R1 in_ready after reset",  in_ready == 1'b0,  int'(in_ready), 0);
    chk("R1 err after reset",       err_o == 1'b0,     int'(err_o), 0);
    reg_rd_chk("R1 enable reset value", 12'h000, 0);

    // R2 readback
    reg_wr(12'h000, 1);
    reg_rd_chk("R2 enable readback", 12'h000, 1);
    set_cfg(4'hB);
    reg_rd_chk("R2 config readback", 12'h004, 11);
    reg_wr(12'h00C, 6);
    reg_rd_chk("R2 bank readback", 12'h00C, 6);

    // R3 relay and table-off bypass
    set_cfg(1);
    cur_req = "R3 relay";
    send(1023, 0, 517, 0);
    send(5, 700, 1, 0);
    drain();
    set_cfg(0);
    cur_req = "R3 table off";
    send(300, 2, 1000, 0);
    drain();

    // R4 wide-mode fill across all banks
    for (int k = 0; k < 32; k++)
      set12(pool(k), int'($urandom % 4096), int'($urandom % 4096), int'($urandom % 4096));
    set12(2, 4000, 100, 50);
    set12(3, 200, 300, 10);
    set12(1022, 10, 20, 30);
    set12(1023, 4095, 1, 2);
    set_cfg(2);
    cur_req = "R4 R10 absolute";
    for (int k = 0; k < 32; k++) send(pool(k), pool((k + 5) % 32), pool((k + 11) % 32), 0);
    send(1023, 1022, 1023, 0);
    send(3, 3, 3, 0);
    drain();

    // R6 delta rising with saturation
    set_cfg(4'hA);
    cur_req = "R6 delta rising";
    send(3, 3, 3, 0);
    send(1023, 1023, 1023, 0);
    for (int k = 0; k < 32; k++) send(pool(k), pool((k + 3) % 32), pool((k + 7) % 32), 0);
    drain();

    // R7 delta falling with floor
    set_cfg(4'hE);
    cur_req = "R7 delta falling";
    send(3, 3, 3, 0);
    for (int k = 0; k < 32; k++) send(pool(k), pool((k + 9) % 32), pool((k + 1) % 32), 0);
    drain();

    // R5 narrow mode; secondary window ignored
    set10(517, 1000, 3, 512);
    set10(516, 1, 2, 3);
    reg_wr(12'h800 + 4 * 5, 12'hABC);
    set_cfg(2);
    cur_req = "R5 narrow layout";
    send(517, 517, 517, 0);
    send(516, 517, 516, 0);
    drain();

    // R8 latency
    set_cfg(1);
    bp_mode = 0;
    repeat (2) @(negedge clk);
    cur_req = "R8 latency";
    send(9, 9, 9, 0);
    chk("R8 not valid one edge early", out_valid == 1'b0, int'(out_valid), 0);
    @(posedge clk);
    #1 chk("R8 valid after second stage", out_valid == 1'b1, int'(out_valid), 1);
    drain();

    // R8 random back-pressure on delta lookups
    set_cfg(4'hA);
    bp_mode = 1;
    cur_req = "R8 backpressure";
    for (int n = 0; n < 300; n++) begin
      int k;
      k = int'($urandom % 32);
      send(pool(k), pool((k + 13) % 32), pool((k + 21) % 32), 0);
    end
    bp_mode = 0;
    drain();
    chk("R8 queue empty", q.size() == 0, q.size(), 0);

    // R1 + R8: stop while stalled
    set_cfg(1);
    bp_mode = 2;
    repeat (2) @(negedge clk);
    cur_req = "R1 stop while stalled";
    send(11, 22, 33, 0);
    send(44, 55, 66, 0);
    reg_wr(12'h000, 0);
    @(negedge clk);
    chk("R1 out_valid while stopped", out_valid == 1'b0, int'(out_valid), 0);
    chk("R1 in_ready while stopped",  in_ready == 1'b0,  int'(in_ready), 0);
    bp_mode = 0;
    repeat (3) @(negedge clk);
    chk("R1 still idle with ready high", out_valid == 1'b0 && in_ready == 1'b0,
        int'({out_valid, in_ready}), 0);
    chk("R1 pixels retained", q.size() == 2, q.size(), 2);
    reg_wr(12'h000, 1);
    drain();
    chk("R1 held pixels delivered", q.size() == 0, q.size(), 0);

    // R9 line geometry
    reg_wr(12'h008, (4 << 16) | 2);
    reg_rd_chk("R2 size readback", 12'h008, (4 << 16) | 2);
    cur_req = "R9 geometry";
    for (int i = 0; i < 4; i++) send(i, i, i, i == 3);
    @(negedge clk);
    chk("R9 no error on correct line", err_o == 1'b0, int'(err_o), 0);
    for (int i = 0; i < 3; i++) send(i, i, i, i == 2);
    @(negedge clk);
    chk("R9 error on short line", err_o == 1'b1, int'(err_o), 1);
    for (int i = 0; i < 4; i++) send(i, i, i, i == 3);
    @(negedge clk);
    chk("R9 error sticky", err_o == 1'b1, int'(err_o), 1);
    reg_wr(12'h008, (4 << 16) | 2);
    @(negedge clk);
    chk("R9 cleared by size write", err_o == 1'b0, int'(err_o), 0);
    for (int i = 0; i < 4; i++) send(i, i, i, i == 3);
    @(negedge clk);
    chk("R9 column restarted", err_o == 1'b0, int'(err_o), 0);
    drain();

    finish_up();
  end
endmodule